// File: doc/BRIEF.md
# Time-of-Day Counter with Per-Unit Alarms

This block keeps the time of day in three chained counters (seconds, minutes and hours) and raises an interrupt when an alarm condition is met. A programmable prescaler divides the block clock into a one-second strobe. Only that strobe advances the seconds counter. A seconds wrap passes a single-cycle carry to the minutes counter, and a minutes wrap passes one on to the hours counter in the same way.

Software uses a flat register interface. Each write lands in one clock, and each read returns its data one clock after the address is presented. Through it software can start and stop counting, clear the counters, set the prescaler divisor, preset any counter, and program one alarm per unit. Each alarm has its own mode bit. In value mode it fires when its counter steps onto the programmed value. In step mode it fires on every advance of that counter. Alarm events are kept in sticky flags, and software clears them by writing ones. The interrupt output is asserted while any flag whose alarm is enabled is set.

Top module: `tod_alarm_core`

## Requirements
- R1: With run set and divisor D written to address 1, the seconds counter advances once every D clocks. The first advance comes D clocks after the clock that starts the run. A divisor of 0 behaves as 1.
- R2: Seconds and minutes count 0 to 59 and hours count 0 to 23, each wrapping to 0. Minutes advance in the same clock as a seconds wrap. Hours advance in the same clock as a minutes wrap. No other counting event moves them.
- R3: While the run bit (bit 0 of the control register, address 0) is 0, no counter moves.
- R4: After reset, all counters, flags, alarm registers and the run bit are 0 and the divisor is DIV_RESET. Writing the control register with bit 1 set returns every counter and the prescaler to 0 in that clock, while bit 0 sets the run bit. Bit 1 always reads back as 0.
- R5: A write to address 2, 3 or 4 loads the seconds, minutes or hours counter. A value above the unit's maximum loads 0. A load wins over an advance in the same clock, and that unit then produces no carry.
- R6: An alarm register (address 5, 6 or 7 for seconds, minutes, hours) holds the compare value in bits 5:0, the mode in bit 6 and the enable in bit 7. With mode 0, the unit's flag sets in the clock its counter advances onto the compare value. A load onto that value does not set it.
- R7: With alarm mode 1, the unit's flag sets on every advance of its counter, including the wrap to 0.
- R8: Status flags (address 8: bit 0 seconds, bit 1 minutes, bit 2 hours) are sticky. Writing 1 to the same bit of address 9 clears a flag. Writing 0 has no effect. A set and a clear in the same clock leave the flag set.
- R9: Flags set whether or not their alarm is enabled. irq is a register that is high when some flag whose enable bit is 1 is set. It reflects a change of an enable bit one clock after the write.
- R10: rd_data returns, one clock after rd_addr: the run bit at 0, the divisor at 1, the live counters at 2 to 4, the alarm registers at 5 to 7, the flags at 8, and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | DATA_W (20) | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | DATA_W (20) | Registered read data |
| tod_sec | output | UNIT_W (6) | Seconds counter |
| tod_min | output | UNIT_W (6) | Minutes counter |
| tod_hr | output | UNIT_W (6) | Hours counter |
| irq | output | 1 | Alarm interrupt |

## Verification
The hardest situations to reach from the ports are those where two events meet in a single clock. One is a load landing in the same cycle as a seconds advance out of 59, where the carry must be suppressed. The other is an alarm hit landing in the same cycle as a write that clears its flag. With the divisor at 1, every clock is an advance, so the bench can place the load or the clear on a chosen edge simply by counting clocks after the run starts. The 23:59:59 rollover is reached by presetting the counters. A sweep then runs a whole day at one advance per clock and compares every cycle against an arithmetic model.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int ADDR_W     = 4;
  localparam int NUM_UNITS  = 3;
  localparam int MINSEC_MAX = 59;
  localparam int HOUR_MAX   = 23;
  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_CLR_BIT = 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL    = 4'd0,
    REG_DIV     = 4'd1,
    REG_LD_SEC  = 4'd2,
    REG_LD_MIN  = 4'd3,
    REG_LD_HR   = 4'd4,
    REG_ALM_SEC = 4'd5,
    REG_ALM_MIN = 4'd6,
    REG_ALM_HR  = 4'd7,
    REG_STATUS  = 4'd8,
    REG_INT_CLR = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int DIV_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             strobe
);
  logic [DIV_W-1:0] pcnt_q;
  logic [DIV_W-1:0] last;

  // divisor 0 is treated as 1; >= keeps a shrunk divisor from stalling
  assign last   = (div == '0) ? '0 : div - DIV_W'(1);
  assign strobe = run && (pcnt_q >= last);

  always_ff @(posedge clk) begin
    if (rst || clr)   pcnt_q <= '0;
    else if (strobe)  pcnt_q <= '0;
    else if (run)     pcnt_q <= pcnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/tod_unit.sv
module tod_unit #(
  parameter int W   = 6,
  parameter int MAX = 59
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [W-1:0] alm_val_i,
  input  logic         alm_mode_i,
  output logic [W-1:0] cnt_o,
  output logic         carry_o,
  output logic         hit_o
);
  localparam logic [W-1:0] TOP = W'(MAX);

  logic         adv;
  logic         at_top;
  logic [W-1:0] nxt;

  // a load or a counter clear in the same cycle wins over the advance
  assign adv     = adv_i && !ld_i && !clr;
  assign at_top  = (cnt_o == TOP);
  assign nxt     = at_top ? '0 : cnt_o + W'(1);
  assign carry_o = adv && at_top;
  assign hit_o   = adv && (alm_mode_i || (nxt == alm_val_i));

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_o <= '0;
    else if (ld_i)   cnt_o <= (ld_val_i > TOP) ? '0 : ld_val_i;
    else if (adv)    cnt_o <= nxt;
  end
endmodule

// File: rtl/tod_flags.sv
module tod_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] nxt;

  // set has priority over a simultaneous clear
  assign nxt = (flags_o & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      flags_o <= nxt;
      irq_o   <= |(nxt & en_i);
    end
  end
endmodule

// File: rtl/tod_alarm_core.sv
module tod_alarm_core
  import tod_alarm_pkg::*;
#(
  parameter int DIV_W     = 20,
  parameter int UNIT_W    = 6,
  parameter int DIV_RESET = 32768,
  localparam int DATA_W   = (DIV_W > UNIT_W + 2) ? DIV_W : UNIT_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [UNIT_W-1:0] tod_sec,
  output logic [UNIT_W-1:0] tod_min,
  output logic [UNIT_W-1:0] tod_hr,
  output logic              irq
);
  localparam int ALM_W    = UNIT_W + 2;
  localparam int MODE_BIT = UNIT_W;
  localparam int EN_BIT   = UNIT_W + 1;

  logic                 run_q;
  logic [DIV_W-1:0]     div_q;
  logic [ALM_W-1:0]     alm_q [NUM_UNITS];
  logic [UNIT_W-1:0]    cnt   [NUM_UNITS];
  logic [NUM_UNITS-1:0] adv, carry, hit, ld, alm_en, int_clr, status_q;
  logic                 ctrl_wr, cnt_clr, strobe;

  assign ctrl_wr = wr_en && (wr_addr == REG_CTRL);
  assign cnt_clr = ctrl_wr && wr_data[CTRL_CLR_BIT];
  assign int_clr = (wr_en && (wr_addr == REG_INT_CLR)) ? wr_data[NUM_UNITS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      div_q <= DIV_W'(DIV_RESET);
      for (int i = 0; i < NUM_UNITS; i++) alm_q[i] <= '0;
    end else begin
      if (ctrl_wr) run_q <= wr_data[CTRL_RUN_BIT];
      if (wr_en && (wr_addr == REG_DIV)) div_q <= wr_data[DIV_W-1:0];
      for (int i = 0; i < NUM_UNITS; i++)
        if (wr_en && (wr_addr == ADDR_W'(int'(REG_ALM_SEC) + i)))
          alm_q[i] <= wr_data[ALM_W-1:0];
    end
  end

  tod_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst(rst), .clr(cnt_clr), .run(run_q), .div(div_q), .strobe(strobe)
  );

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
    localparam int UMAX = (i == NUM_UNITS - 1) ? HOUR_MAX : MINSEC_MAX;
    localparam logic [ADDR_W-1:0] LD_A = ADDR_W'(int'(REG_LD_SEC) + i);

    if (i == 0) begin : g_first
      assign adv[i] = strobe;
    end else begin : g_chain
      assign adv[i] = carry[i-1];
    end

    assign ld[i]     = wr_en && (wr_addr == LD_A);
    assign alm_en[i] = alm_q[i][EN_BIT];

    tod_unit #(.W(UNIT_W), .MAX(UMAX)) u_unit (
      .clk(clk), .rst(rst), .clr(cnt_clr),
      .adv_i(adv[i]), .ld_i(ld[i]), .ld_val_i(wr_data[UNIT_W-1:0]),
      .alm_val_i(alm_q[i][UNIT_W-1:0]), .alm_mode_i(alm_q[i][MODE_BIT]),
      .cnt_o(cnt[i]), .carry_o(carry[i]), .hit_o(hit[i])
    );
  end

  tod_flags #(.N(NUM_UNITS)) u_flags (
    .clk(clk), .rst(rst), .set_i(hit), .clr_i(int_clr), .en_i(alm_en),
    .flags_o(status_q), .irq_o(irq)
  );

  assign tod_sec = cnt[0];
  assign tod_min = cnt[1];
  assign tod_hr  = cnt[2];

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        REG_CTRL:    rd_data <= DATA_W'(run_q);
        REG_DIV:     rd_data <= DATA_W'(div_q);
        REG_LD_SEC:  rd_data <= DATA_W'(cnt[0]);
        REG_LD_MIN:  rd_data <= DATA_W'(cnt[1]);
        REG_LD_HR:   rd_data <= DATA_W'(cnt[2]);
        REG_ALM_SEC: rd_data <= DATA_W'(alm_q[0]);
        REG_ALM_MIN: rd_data <= DATA_W'(alm_q[1]);
        REG_ALM_HR:  rd_data <= DATA_W'(alm_q[2]);
        REG_STATUS:  rd_data <= DATA_W'(status_q);
        default:     rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tod_alarm_core_chk.sv
module tod_alarm_core_chk
  import tod_alarm_pkg::*;
#(
  parameter int UNIT_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [2:0]        wr_bits,
  input logic [UNIT_W-1:0] sec,
  input logic [UNIT_W-1:0] min,
  input logic [UNIT_W-1:0] hr,
  input logic [2:0]        status,
  input logic              irq
);
  p_sec_range_r2: assert property (@(posedge clk) disable iff (rst)
    sec <= UNIT_W'(MINSEC_MAX));
  p_hr_range_r2: assert property (@(posedge clk) disable iff (rst)
    hr <= UNIT_W'(HOUR_MAX));
  p_min_carry_r2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(min) && !$past(wr_en)) |-> ($past(sec) == UNIT_W'(MINSEC_MAX) && sec == '0));
  p_hr_carry_r2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(hr) && !$past(wr_en)) |->
      ($past(min) == UNIT_W'(MINSEC_MAX) && $past(sec) == UNIT_W'(MINSEC_MAX)));
  p_sec_flag_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(status[0]) |-> !$stable(sec));
  p_min_flag_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(status[1]) |-> !$stable(min));
  p_hr_flag_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(status[2]) |-> !$stable(hr));
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && $past(wr_addr) == REG_INT_CLR && $past(wr_bits[0]) && $stable(sec))
      |-> !status[0]);
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (status != '0));
endmodule

bind tod_alarm_core tod_alarm_core_chk #(.UNIT_W(UNIT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_bits(wr_data[2:0]), .sec(tod_sec), .min(tod_min), .hr(tod_hr),
  .status(status_q), .irq(irq)
);

// File: tb/tod_alarm_core_bench.sv
`timescale 1ns/1ps
module tod_alarm_core_bench;
  import tod_alarm_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [19:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [19:0] rd_data;
  logic [5:0]  tod_sec, tod_min, tod_hr;
  logic        irq;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tod_alarm_core u_tod_alarm_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tod_sec(tod_sec), .tod_min(tod_min),
    .tod_hr(tod_hr), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [19:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    rd_addr = a;
    step();
    v = int'(rd_data);
  endtask

  function automatic int tod(input int h, input int m, input int s);
    return h * 4096 + m * 64 + s;
  endfunction

  function automatic int now();
    return tod(int'(tod_hr), int'(tod_min), int'(tod_sec));
  endfunction

  initial begin
    int v;
    int hh, mm, ss;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // reset state
    chk("R4 reset counters", now(), 0);
    chk("R4 reset irq", int'(irq), 0);
    rd(REG_DIV, v);    chk("R4 reset divisor", v, 32768);
    rd(REG_STATUS, v); chk("R4 reset flags", v, 0);
    rd(REG_CTRL, v);   chk("R4 reset run", v, 0);

    // read map
    wr(REG_ALM_MIN, 20'h45);
    rd(REG_ALM_MIN, v); chk("R10 alarm readback", v, 'h45);
    wr(REG_ALM_MIN, 20'h0);

    // prescaler divisor 3
    wr(REG_DIV, 20'd3);
    wr(REG_CTRL, 20'd3);
    for (int k = 1; k <= 12; k++) begin
      step(); chk("R1 divide by 3", int'(tod_sec), k / 3);
    end
    wr(REG_CTRL, 20'd2);
    chk("R4 counter clear", now(), 0);
    // divisor 0 acts as 1
    wr(REG_DIV, 20'd0);
    wr(REG_CTRL, 20'd3);
    for (int k = 1; k <= 5; k++) begin
      step(); chk("R1 divisor zero", int'(tod_sec), k);
    end
    wr(REG_CTRL, 20'd2);

    // hold while stopped
    wr(REG_DIV, 20'd1);
    wr(REG_LD_SEC, 20'd20);
    wr(REG_LD_MIN, 20'd7);
    wr(REG_LD_HR, 20'd3);
    rd(REG_LD_MIN, v); chk("R10 counter readback", v, 7);
    repeat (10) step();
    chk("R3 stopped hold", now(), tod(3, 7, 20));

    // loads above maximum
    wr(REG_LD_MIN, 20'd60); chk("R5 minute over max", int'(tod_min), 0);
    wr(REG_LD_HR, 20'd24);  chk("R5 hour over max", int'(tod_hr), 0);
    wr(REG_LD_HR, 20'd23);  chk("R5 hour at max", int'(tod_hr), 23);

    // load colliding with an advance out of 59
    wr(REG_CTRL, 20'd2);
    wr(REG_LD_SEC, 20'd57);
    wr(REG_CTRL, 20'd1);
    step(); chk("R1 first advance", int'(tod_sec), 58);
    step(); chk("R2 reach 59", int'(tod_sec), 59);
    wr(REG_LD_SEC, 20'd30);
    chk("R5 load wins over advance", now(), tod(0, 0, 30));
    step(); chk("R5 count after load", int'(tod_sec), 31);
    wr(REG_CTRL, 20'd2);

    // value-mode alarm on seconds
    wr(REG_INT_CLR, 20'd7);
    wr(REG_ALM_SEC, 20'h85);
    wr(REG_CTRL, 20'd3);
    for (int k = 1; k <= 4; k++) begin
      step(); chk("R6 no early alarm", int'(irq), 0);
    end
    step();
    chk("R6 alarm on match", int'(irq), 1);
    chk("R6 match second", int'(tod_sec), 5);
    wr(REG_CTRL, 20'd0);
    rd(REG_STATUS, v); chk("R6 status after match", v, 1);
    wr(REG_INT_CLR, 20'd0);
    rd(REG_STATUS, v); chk("R8 write zero keeps flag", v, 1);
    chk("R8 irq kept", int'(irq), 1);
    wr(REG_INT_CLR, 20'd1);
    chk("R8 irq after clear", int'(irq), 0);
    rd(REG_STATUS, v); chk("R8 flag cleared", v, 0);
    wr(REG_LD_SEC, 20'd5);
    rd(REG_STATUS, v); chk("R6 load does not fire", v, 0);

    // set and clear in the same cycle
    wr(REG_ALM_SEC, 20'hC0);
    wr(REG_CTRL, 20'd1);
    wr(REG_INT_CLR, 20'd1);
    wr(REG_CTRL, 20'd0);
    rd(REG_STATUS, v); chk("R8 set beats clear", v, 1);

    // step-mode alarm on minutes, seconds alarm disabled
    wr(REG_CTRL, 20'd2);
    wr(REG_INT_CLR, 20'd7);
    wr(REG_ALM_SEC, 20'h00);
    wr(REG_ALM_MIN, 20'hC0);
    wr(REG_LD_SEC, 20'd58);
    wr(REG_CTRL, 20'd1);
    step(); chk("R7 before minute step", int'(irq), 0);
    step();
    chk("R7 irq on minute step", int'(irq), 1);
    chk("R2 minute carry", now(), tod(0, 1, 0));
    wr(REG_CTRL, 20'd0);
    rd(REG_STATUS, v); chk("R9 disabled flag still set", v, 3);
    wr(REG_ALM_MIN, 20'h40);
    step(); chk("R9 irq after disable", int'(irq), 0);
    rd(REG_STATUS, v); chk("R9 flags unchanged by disable", v, 3);

    // day rollover with hour alarm on 0
    wr(REG_CTRL, 20'd2);
    wr(REG_INT_CLR, 20'd7);
    wr(REG_ALM_MIN, 20'h00);
    wr(REG_ALM_HR, 20'h80);
    wr(REG_LD_HR, 20'd23);
    wr(REG_LD_MIN, 20'd59);
    wr(REG_LD_SEC, 20'd58);
    wr(REG_CTRL, 20'd1);
    step();
    chk("R2 23:59:59", now(), tod(23, 59, 59));
    chk("R6 no hour alarm yet", int'(irq), 0);
    step();
    chk("R2 day wrap", now(), 0);
    chk("R6 hour alarm", int'(irq), 1);
    wr(REG_CTRL, 20'd0);
    rd(REG_STATUS, v); chk("R6 all flags at wrap", v, 7);

    // full-day sweep at one advance per clock
    wr(REG_CTRL, 20'd2);
    wr(REG_INT_CLR, 20'd7);
    wr(REG_CTRL, 20'd3);
    hh = 0; mm = 0; ss = 0;
    for (int k = 1; k <= 86401; k++) begin
      step();
      ss++;
      if (ss == 60) begin ss = 0; mm++; end
      if (mm == 60) begin mm = 0; hh++; end
      if (hh == 24) hh = 0;
      chk("R2 sweep", now(), tod(hh, mm, ss));
    end
    wr(REG_CTRL, 20'd2);
    chk("R4 clear after sweep", now(), 0);
    rd(REG_CTRL, v); chk("R4 clear bit reads 0", v, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule